// File: doc/BRIEF.md
# Four-Slot Header Handoff Buffer

This block sits between a header field extractor and a lookup processor. It keeps a small number of header slots, each holding a fixed set of header registers and the packet's memory block identifier. The writing side and the reading side work independently on dual-port storage. A slot moves between them only as a whole. The writer fills a free slot word by word and then commits it. The reader works on a full slot and releases it when the lookup is done.

The block offers the writer the lowest-numbered free slot. It presents to the reader the oldest committed slot, kept in a short order queue, so headers leave in the order they were completed. A per-slot full mask shows ownership. A commit or release that breaks the handoff rules is dropped and sets a sticky error flag.

Top module: `hdr_handoff_buf`

## Requirements
- R1: After reset, fullMask is all zeros, headValid is 0, freeValid is 1 with freeSlot 0, and protoErr is 0.
- R2: freeSlot is the lowest-numbered slot whose fullMask bit is 0. freeValid is 0 exactly when every bit of fullMask is 1.
- R3: A word write (wrEn) lands in register wrIdx of slot wrSlot only while that slot's fullMask bit is 0. A write to a full slot leaves its contents unchanged.
- R4: A commit (wrCommit) to a slot whose bit is 0 sets that bit on the next cycle and records wrPktId as the slot's packet identifier. The word written in the same cycle as the commit is kept.
- R5: A read (rdEn) of slot rdSlot and register rdIdx puts that word on rdData, and the slot's identifier on rdPktId, one cycle later. If the slot's bit is 0 when the read is issued, both outputs read 0.
- R6: While any slot is full, headValid is 1 and headSlot names the full slot committed earliest among those not yet released.
- R7: A release (rdRelease) naming headSlot while it is full clears that slot's bit on the next cycle. The head then moves to the next slot in commit order.
- R8: A commit to a full slot, a release of an empty slot, and a release of a full slot other than headSlot each have no effect on fullMask or the head. Each of them sets protoErr, which stays 1 until reset.
- R9: A valid commit and a valid release of different slots in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write one header register |
| wrSlot | input | 2 | Slot targeted by the write and the commit |
| wrIdx | input | 3 | Register index within the slot |
| wrData | input | 16 | Register value |
| wrCommit | input | 1 | Hand the slot to the reader |
| wrPktId | input | 12 | Packet memory block number stored on commit |
| freeSlot | output | 2 | Lowest-numbered free slot |
| freeValid | output | 1 | At least one slot is free |
| rdEn | input | 1 | Read one header register |
| rdSlot | input | 2 | Slot targeted by the read and the release |
| rdIdx | input | 3 | Register index within the slot |
| rdData | output | 16 | Register value, one cycle after rdEn |
| rdPktId | output | 12 | Slot packet identifier, one cycle after rdEn |
| rdRelease | input | 1 | Return the slot to the writer |
| headSlot | output | 2 | Oldest committed full slot |
| headValid | output | 1 | Some slot is full |
| fullMask | output | 4 | One bit per slot, 1 = holds a complete header |
| protoErr | output | 1 | Sticky handoff rule violation |

## Verification
The bench builds the block with its defaults: four slots, eight 16-bit registers per slot and a 12-bit packet identifier. Eight registers keep each fill short, so the stimulus table can fill every slot, empty it out of allocation order and refill it. This drives the commit order through a wrap of the order queue pointers and reaches the all-full state where freeValid drops. Directed cases then cover a same-cycle commit and release, the three kinds of rejected handoff, and reads of an empty slot.

// File: rtl/hhb_pkg.sv
package hhb_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic memWe;   // word write accepted
    logic idWe;    // commit accepted, store packet id
    logic rdOk;    // read targets a full slot
  } hhbStrobe_t;

endpackage

// File: rtl/hhb_ctrl.sv
module hhb_ctrl
  import hhb_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [SLOT_W-1:0]    wrSlot,
  input  logic                 wrCommit,
  input  logic                 rdEn,
  input  logic [SLOT_W-1:0]    rdSlot,
  input  logic                 rdRelease,
  output hhbStrobe_t           strobe,
  output logic [SLOT_W-1:0]    freeSlot,
  output logic                 freeValid,
  output logic [SLOT_W-1:0]    headSlot,
  output logic                 headValid,
  output logic [NUM_SLOTS-1:0] fullMask,
  output logic                 protoErr
);

  logic [NUM_SLOTS-1:0] fullQ;
  logic [SLOT_W-1:0]    ordQ [NUM_SLOTS];
  logic [SLOT_W-1:0]    headPtrQ, tailPtrQ;
  logic [SLOT_W:0]      cntQ;
  logic                 commitOk, relOk, errQ;

  function automatic logic [SLOT_W-1:0] bump(input logic [SLOT_W-1:0] p);
    return (p == SLOT_W'(NUM_SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  assign headSlot  = ordQ[headPtrQ];
  assign headValid = (cntQ != '0);
  assign commitOk  = wrCommit && !fullQ[wrSlot];
  assign relOk     = rdRelease && fullQ[rdSlot] && headValid && (headSlot == rdSlot);

  // one ownership bit per slot
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        fullQ[s] <= 1'b0;
      end else if (commitOk && (wrSlot == SLOT_W'(s))) begin
        fullQ[s] <= 1'b1;
      end else if (relOk && (rdSlot == SLOT_W'(s))) begin
        fullQ[s] <= 1'b0;
      end
    end
  end

  // commit-order queue
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SLOTS; i++) ordQ[i] <= '0;
      headPtrQ <= '0;
      tailPtrQ <= '0;
      cntQ     <= '0;
    end else begin
      if (commitOk) begin
        ordQ[tailPtrQ] <= wrSlot;
        tailPtrQ       <= bump(tailPtrQ);
      end
      if (relOk) headPtrQ <= bump(headPtrQ);
      case ({commitOk, relOk})
        2'b10:   cntQ <= cntQ + 1'b1;
        2'b01:   cntQ <= cntQ - 1'b1;
        default: cntQ <= cntQ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) errQ <= 1'b0;
    else if ((wrCommit && !commitOk) || (rdRelease && !relOk)) errQ <= 1'b1;
  end

  always_comb begin
    freeSlot = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (!fullQ[i]) freeSlot = SLOT_W'(i);
    end
  end

  assign freeValid    = ~&fullQ;
  assign fullMask     = fullQ;
  assign protoErr     = errQ;
  assign strobe.memWe = wrEn && !fullQ[wrSlot];
  assign strobe.idWe  = commitOk;
  assign strobe.rdOk  = rdEn && fullQ[rdSlot];

endmodule

// File: rtl/hhb_data.sv
module hhb_data
  import hhb_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_REGS  = 8,
  parameter int REG_W     = 16,
  parameter int ID_W      = 12,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int IDX_W  = $clog2(NUM_REGS),
  localparam int DEPTH  = NUM_SLOTS * NUM_REGS,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  hhbStrobe_t        strobe,
  input  logic              rdEn,
  input  logic [SLOT_W-1:0] wrSlot,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [REG_W-1:0]  wrData,
  input  logic [ID_W-1:0]   wrPktId,
  input  logic [SLOT_W-1:0] rdSlot,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [REG_W-1:0]  rdData,
  output logic [ID_W-1:0]   rdPktId
);

  logic [REG_W-1:0]  mem [DEPTH];
  logic [ID_W-1:0]   ids [NUM_SLOTS];
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [REG_W-1:0]  rdDataQ;
  logic [ID_W-1:0]   rdIdQ;
  logic              rdOkQ;

  assign wrAddr = ADDR_W'(wrSlot) * ADDR_W'(NUM_REGS) + ADDR_W'(wrIdx);
  assign rdAddr = ADDR_W'(rdSlot) * ADDR_W'(NUM_REGS) + ADDR_W'(rdIdx);

  // write side
  always_ff @(posedge clk) begin
    if (strobe.memWe) mem[wrAddr] <= wrData;
    if (strobe.idWe)  ids[wrSlot] <= wrPktId;
  end

  // read side, registered
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdDataQ <= '0;
      rdIdQ   <= '0;
      rdOkQ   <= 1'b0;
    end else if (rdEn) begin
      rdDataQ <= mem[rdAddr];
      rdIdQ   <= ids[rdSlot];
      rdOkQ   <= strobe.rdOk;
    end
  end

  assign rdData  = rdOkQ ? rdDataQ : '0;
  assign rdPktId = rdOkQ ? rdIdQ   : '0;

endmodule

// File: rtl/hdr_handoff_buf.sv
module hdr_handoff_buf
  import hhb_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_REGS  = 8,
  parameter int REG_W     = 16,
  parameter int ID_W      = 12,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int IDX_W  = $clog2(NUM_REGS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [SLOT_W-1:0]    wrSlot,
  input  logic [IDX_W-1:0]     wrIdx,
  input  logic [REG_W-1:0]     wrData,
  input  logic                 wrCommit,
  input  logic [ID_W-1:0]      wrPktId,
  output logic [SLOT_W-1:0]    freeSlot,
  output logic                 freeValid,
  input  logic                 rdEn,
  input  logic [SLOT_W-1:0]    rdSlot,
  input  logic [IDX_W-1:0]     rdIdx,
  output logic [REG_W-1:0]     rdData,
  output logic [ID_W-1:0]      rdPktId,
  input  logic                 rdRelease,
  output logic [SLOT_W-1:0]    headSlot,
  output logic                 headValid,
  output logic [NUM_SLOTS-1:0] fullMask,
  output logic                 protoErr
);

  hhbStrobe_t strobe;

  hhb_ctrl #(.NUM_SLOTS(NUM_SLOTS)) uCtrl (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrSlot(wrSlot), .wrCommit(wrCommit),
    .rdEn(rdEn), .rdSlot(rdSlot), .rdRelease(rdRelease),
    .strobe(strobe),
    .freeSlot(freeSlot), .freeValid(freeValid),
    .headSlot(headSlot), .headValid(headValid),
    .fullMask(fullMask), .protoErr(protoErr)
  );

  hhb_data #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_REGS(NUM_REGS), .REG_W(REG_W), .ID_W(ID_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdEn(rdEn),
    .wrSlot(wrSlot), .wrIdx(wrIdx), .wrData(wrData), .wrPktId(wrPktId),
    .rdSlot(rdSlot), .rdIdx(rdIdx), .rdData(rdData), .rdPktId(rdPktId)
  );

endmodule

// File: rtl/hdr_handoff_buf_chk.sv
module hdr_handoff_buf_chk #(
  parameter int NUM_SLOTS = 4,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [SLOT_W-1:0]    wrSlot,
  input logic                 wrCommit,
  input logic [SLOT_W-1:0]    rdSlot,
  input logic                 rdRelease,
  input logic [SLOT_W-1:0]    freeSlot,
  input logic                 freeValid,
  input logic [SLOT_W-1:0]    headSlot,
  input logic                 headValid,
  input logic [NUM_SLOTS-1:0] fullMask,
  input logic                 protoErr
);

  logic [NUM_SLOTS-1:0] lowMask;
  always_comb begin
    lowMask = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (SLOT_W'(i) < freeSlot) lowMask[i] = 1'b1;
    end
  end

  assert_free_lowest_R2: assert property (@(posedge clk) disable iff (!rstN)
    freeValid |-> (!fullMask[freeSlot] && ((fullMask & lowMask) == lowMask)));

  assert_no_free_when_full_R2: assert property (@(posedge clk) disable iff (!rstN)
    (&fullMask) |-> !freeValid);

  assert_commit_sets_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrCommit && !fullMask[wrSlot]) |=> fullMask[$past(wrSlot)]);

  assert_head_is_full_R6: assert property (@(posedge clk) disable iff (!rstN)
    headValid |-> fullMask[headSlot]);

  assert_head_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    headValid == (fullMask != '0));

  assert_release_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdRelease && headValid && (rdSlot == headSlot)) |=> !fullMask[$past(rdSlot)]);

  assert_bad_commit_flags_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrCommit && fullMask[wrSlot]) |=> protoErr);

  assert_bad_release_flags_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdRelease && !fullMask[rdSlot]) |=> protoErr);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);

endmodule

bind hdr_handoff_buf hdr_handoff_buf_chk #(.NUM_SLOTS(NUM_SLOTS)) uChk (
  .clk(clk), .rstN(rstN), .wrSlot(wrSlot), .wrCommit(wrCommit),
  .rdSlot(rdSlot), .rdRelease(rdRelease), .freeSlot(freeSlot),
  .freeValid(freeValid), .headSlot(headSlot), .headValid(headValid),
  .fullMask(fullMask), .protoErr(protoErr)
);

// File: tb/hdr_handoff_buf_test.sv
module hdr_handoff_buf_test;

  localparam int NUM_SLOTS = 4;
  localparam int NUM_REGS  = 8;
  localparam int REG_W     = 16;
  localparam int ID_W      = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, wrCommit = 1'b0, rdEn = 1'b0, rdRelease = 1'b0;
  logic [1:0]  wrSlot = '0, rdSlot = '0;
  logic [2:0]  wrIdx = '0, rdIdx = '0;
  logic [15:0] wrData = '0;
  logic [11:0] wrPktId = '0;
  logic [1:0]  freeSlot, headSlot;
  logic        freeValid, headValid, protoErr;
  logic [15:0] rdData;
  logic [11:0] rdPktId;
  logic [3:0]  fullMask;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;   // 250 MHz

  hdr_handoff_buf #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_REGS(NUM_REGS), .REG_W(REG_W), .ID_W(ID_W)
  ) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSlot(wrSlot), .wrIdx(wrIdx),
    .wrData(wrData), .wrCommit(wrCommit), .wrPktId(wrPktId),
    .freeSlot(freeSlot), .freeValid(freeValid), .rdEn(rdEn), .rdSlot(rdSlot),
    .rdIdx(rdIdx), .rdData(rdData), .rdPktId(rdPktId), .rdRelease(rdRelease),
    .headSlot(headSlot), .headValid(headValid), .fullMask(fullMask),
    .protoErr(protoErr)
  );

  // {isRelease, pktId[11:0], slot[1:0], expMask[3:0], expHeadValid, expHead[1:0]}
  localparam int NV = 10;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 12'h011, 2'd0, 4'b0001, 1'b1, 2'd0},
    {1'b0, 12'h022, 2'd1, 4'b0011, 1'b1, 2'd0},
    {1'b0, 12'h033, 2'd2, 4'b0111, 1'b1, 2'd0},
    {1'b1, 12'h011, 2'd0, 4'b0110, 1'b1, 2'd1},
    {1'b0, 12'h044, 2'd0, 4'b0111, 1'b1, 2'd1},
    {1'b0, 12'h055, 2'd3, 4'b1111, 1'b1, 2'd1},
    {1'b1, 12'h022, 2'd1, 4'b1101, 1'b1, 2'd2},
    {1'b1, 12'h033, 2'd2, 4'b1001, 1'b1, 2'd0},
    {1'b1, 12'h044, 2'd0, 4'b1000, 1'b1, 2'd3},
    {1'b1, 12'h055, 2'd3, 4'b0000, 1'b0, 2'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] word(input logic [11:0] id, input int idx);
    return {id[7:0], 8'(idx)};
  endfunction

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // fill all registers of a slot, commit on the last word, optional release
  task automatic fillSlot(input logic [1:0] slot, input logic [11:0] id,
                          input logic relOn, input logic [1:0] relSlot);
    for (int i = 0; i < NUM_REGS; i++) begin
      wrEn = 1'b1; wrSlot = slot; wrIdx = 3'(i); wrData = word(id, i);
      wrCommit = (i == NUM_REGS - 1); wrPktId = id;
      rdRelease = relOn && (i == NUM_REGS - 1); rdSlot = relSlot;
      @(negedge clk);
    end
    wrEn = 1'b0; wrCommit = 1'b0; rdRelease = 1'b0;
  endtask

  task automatic readWord(input logic [1:0] slot, input int idx,
                          output logic [15:0] d, output logic [11:0] id);
    rdEn = 1'b1; rdSlot = slot; rdIdx = 3'(idx);
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData; id = rdPktId;
  endtask

  task automatic releaseSlot(input logic [1:0] slot);
    rdRelease = 1'b1; rdSlot = slot;
    @(negedge clk);
    rdRelease = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [11:0] id;
    doReset();
    chk("R1 fullMask", 32'(fullMask), 0);
    chk("R1 headValid", 32'(headValid), 0);
    chk("R1 freeValid", 32'(freeValid), 1);
    chk("R1 freeSlot", 32'(freeSlot), 0);
    chk("R1 protoErr", 32'(protoErr), 0);

    // table walk: fill/release sequence crossing the order queue wrap
    for (int k = 0; k < NV; k++) begin
      logic [21:0] v;
      v = VEC[k];
      if (!v[21]) begin
        chk("R2 freeSlot before fill", 32'(freeSlot), 32'(v[8:7]));
        fillSlot(v[8:7], v[20:9], 1'b0, 2'd0);
      end else begin
        chk("R6 head order", 32'(headSlot), 32'(v[8:7]));
        for (int i = 0; i < NUM_REGS; i += 3) begin
          readWord(v[8:7], i, d, id);
          chk("R5 read word", 32'(d), 32'(word(v[20:9], i)));
        end
        chk("R4 packet id", 32'(id), 32'(v[20:9]));
        releaseSlot(v[8:7]);
      end
      chk("R4/R7 fullMask", 32'(fullMask), 32'(v[6:3]));
      chk("R6 headValid", 32'(headValid), 32'(v[2]));
      if (v[2]) chk("R6 headSlot", 32'(headSlot), 32'(v[1:0]));
      chk("R2 freeValid", 32'(freeValid), 32'(v[6:3] != 4'hF));
    end
    chk("R8 no error after legal traffic", 32'(protoErr), 0);

    // R3: write into a full slot is dropped
    fillSlot(2'd0, 12'h0A1, 1'b0, 2'd0);
    wrEn = 1'b1; wrSlot = 2'd0; wrIdx = 3'd2; wrData = 16'hBEEF;
    @(negedge clk);
    wrEn = 1'b0;
    readWord(2'd0, 2, d, id);
    chk("R3 full slot write ignored", 32'(d), 32'(word(12'h0A1, 2)));

    // R9: commit slot1 and release slot0 in the same cycle
    fillSlot(2'd1, 12'h0B2, 1'b1, 2'd0);
    chk("R9 fullMask", 32'(fullMask), 32'b0010);
    chk("R9 headSlot", 32'(headSlot), 1);
    chk("R9 protoErr", 32'(protoErr), 0);
    readWord(2'd1, 7, d, id);
    chk("R9 new slot data", 32'(d), 32'(word(12'h0B2, 7)));
    chk("R9 new slot id", 32'(id), 32'h0B2);

    // R5: read of an empty slot returns zero
    readWord(2'd0, 0, d, id);
    chk("R5 empty slot data", 32'(d), 0);
    chk("R5 empty slot id", 32'(id), 0);

    // R8: release of an empty slot
    releaseSlot(2'd2);
    chk("R8 empty release mask", 32'(fullMask), 32'b0010);
    chk("R8 empty release flag", 32'(protoErr), 1);
    @(negedge clk);
    chk("R8 flag sticky", 32'(protoErr), 1);

    // R1 again: reset clears everything
    doReset();
    chk("R1 mask after reset", 32'(fullMask), 0);
    chk("R1 flag after reset", 32'(protoErr), 0);
    chk("R1 headValid after reset", 32'(headValid), 0);

    // R8: release of a full slot that is not the head
    fillSlot(2'd0, 12'h0C3, 1'b0, 2'd0);
    fillSlot(2'd1, 12'h0D4, 1'b0, 2'd0);
    releaseSlot(2'd1);
    chk("R8 non-head release mask", 32'(fullMask), 32'b0011);
    chk("R8 non-head release head", 32'(headSlot), 0);
    chk("R8 non-head release flag", 32'(protoErr), 1);

    // R8: commit to a full slot
    doReset();
    fillSlot(2'd0, 12'h0E5, 1'b0, 2'd0);
    wrCommit = 1'b1; wrSlot = 2'd0; wrPktId = 12'h0FF;
    @(negedge clk);
    wrCommit = 1'b0;
    chk("R8 full commit mask", 32'(fullMask), 32'b0001);
    chk("R8 full commit flag", 32'(protoErr), 1);
    readWord(2'd0, 0, d, id);
    chk("R8 full commit keeps id", 32'(id), 32'h0E5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule